// File: doc/BRIEF.md
# Reservation Wait Stall Unit

This block holds a single load-reserved reservation for one hart and carries out the two wait-on-reservation instructions: one that waits with no time limit and one that gives up after a short, bounded delay. When either instruction issues with a live reservation, the unit raises `stall` and keeps it high until it sees a wake event. It then pulses `done` so the pipeline moves on to the next instruction, and it drops the reservation.

A wake event is any one of these: loss of the reservation (a snooped store from another hart into the reserved 64-byte granule), any pending interrupt line (the unit sees pending lines only, with no masking), a debug request for early completion, or expiry of the timeout counter for the short-timeout variant. If an encoding issues while the enable bit is low, the unit reports an illegal instruction and does not wait. Store-conditional requests check the same reservation and report success.

Top module: `wrs_stall_unit`

## Requirements
- R1: An instruction is accepted only on an exact match: 32'h00D00073 selects the untimed wait and 32'h01D00073 selects the timed wait. Any other word produces no stall, done or illegal pulse.
- R2: When `ext_en` is 0, a matching word pulses `illegal` for one cycle, one cycle after issue. It raises neither `stall` nor `done` and leaves the reservation unchanged.
- R3: `lr_valid` registers a reservation on address bits [31:6] of `lr_addr`, effective from the next cycle. An LR in a cycle takes priority over every clearing event in that cycle.
- R4: A snooped store (`snoop_valid`) whose address bits [31:6] equal the reserved granule invalidates the reservation. A store to another granule has no effect.
- R5: `sc_ok` pulses one cycle after `sc_valid` exactly when a reservation is held and bits [31:6] match. Every store-conditional clears the reservation.
- R6: If a wake condition already holds in the issue cycle (including no valid reservation), `done` pulses the next cycle and `stall` never rises.
- R7: Otherwise `stall` is high from the cycle after issue. A wake event seen in cycle W drops `stall` and pulses `done` at W+1. `stall` and `done` are never high together, and words that arrive while stalled are ignored.
- R8: The timed wait ends on its own after exactly TIMEOUT_CYC stall cycles (default 256). The untimed wait has no limit.
- R9: Any set bit of `irq_pending` ends a stall, with no masking.
- R10: `dbg_wake` ends a stall early.
- R11: Completion of a wait clears the reservation, so a following store-conditional fails.
- R12: After reset, all outputs are 0 and no reservation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | Instruction word strobe |
| insn | input | 32 | Instruction word |
| ext_en | input | 1 | Enables the wait instructions |
| lr_valid | input | 1 | Load-reserved request |
| lr_addr | input | XLEN | Load-reserved address |
| sc_valid | input | 1 | Store-conditional request |
| sc_addr | input | XLEN | Store-conditional address |
| snoop_valid | input | 1 | Store from another hart observed |
| snoop_addr | input | XLEN | Address of the snooped store |
| irq_pending | input | IRQ_W | Pending interrupt lines, before masking |
| dbg_wake | input | 1 | Forces early completion of a stall |
| stall | output | 1 | Wait instruction in progress |
| done | output | 1 | One-cycle pulse: wait finished, advance PC |
| illegal | output | 1 | One-cycle pulse: wait issued while disabled |
| sc_ok | output | 1 | One-cycle pulse: store-conditional succeeded |

## Verification
Every output is registered, so each result is due exactly one clock after the input cycle that causes it. For example, `done` or `illegal` comes one cycle after issue or after the wake cycle, `sc_ok` one cycle after `sc_valid`, and a new reservation state one cycle after LR, SC or snoop. The bench drives inputs shortly after a rising edge and samples all four outputs shortly after the next one, comparing them with a cycle model that advances by the same single step. The timed-wait duration is measured by counting the sampled cycles in which `stall` is high.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

    localparam logic [6:0]  OPC_SYSTEM   = 7'b1110011;
    localparam logic [11:0] F12_WAIT_NTO = 12'b000000001101;
    localparam logic [11:0] F12_WAIT_STO = 12'b000000011101;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } wait_state_e;

    typedef struct packed {
        wait_state_e state;
        logic        stall;
        logic        done;
        logic        illegal;
        logic        timed;
    } wait_ctl_t;

endpackage

// File: rtl/wrs_decode.sv
module wrs_decode
    import wrs_pkg::*;
(
    input  logic [31:0] insn_i,
    output logic        is_nto_o,
    output logic        is_sto_o
);

    logic fields_zero;

    always_comb begin
        fields_zero = (insn_i[19:15] == 5'd0) && (insn_i[14:12] == 3'd0) &&
                      (insn_i[11:7] == 5'd0) && (insn_i[6:0] == OPC_SYSTEM);
        is_nto_o    = fields_zero && (insn_i[31:20] == F12_WAIT_NTO);
        is_sto_o    = fields_zero && (insn_i[31:20] == F12_WAIT_STO);
    end

endmodule

// File: rtl/wrs_resv.sv
module wrs_resv #(
    parameter int XLEN     = 32,
    parameter int GRAN_LSB = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lr_valid_i,
    input  logic [XLEN-1:0] lr_addr_i,
    input  logic            sc_valid_i,
    input  logic [XLEN-1:0] sc_addr_i,
    input  logic            snoop_valid_i,
    input  logic [XLEN-1:0] snoop_addr_i,
    input  logic            clear_i,
    output logic            valid_o,
    output logic            snoop_hit_o,
    output logic            sc_ok_o
);

    localparam int TAG_W = XLEN - GRAN_LSB;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic             sc_ok;
    } resv_t;

    resv_t resv_d, resv_q;
    logic  sc_match;

    wire unused_low_bits = ^{lr_addr_i[GRAN_LSB-1:0], sc_addr_i[GRAN_LSB-1:0],
                             snoop_addr_i[GRAN_LSB-1:0]};

    always_comb begin
        snoop_hit_o = snoop_valid_i && resv_q.valid &&
                      (snoop_addr_i[XLEN-1:GRAN_LSB] == resv_q.tag);
        sc_match    = sc_valid_i && resv_q.valid &&
                      (sc_addr_i[XLEN-1:GRAN_LSB] == resv_q.tag);
        resv_d       = resv_q;
        resv_d.sc_ok = sc_match;
        if (lr_valid_i) begin
            resv_d.valid = 1'b1;
            resv_d.tag   = lr_addr_i[XLEN-1:GRAN_LSB];
        end else if (sc_valid_i || snoop_hit_o || clear_i) begin
            resv_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resv_q <= '0;
        else        resv_q <= resv_d;
    end

    assign valid_o = resv_q.valid;
    assign sc_ok_o = resv_q.sc_ok;

    AST_LR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        lr_valid_i |=> valid_o); // R3
    AST_SNOOP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_hit_o && !lr_valid_i) |=> !valid_o); // R4
    AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid_i && !lr_valid_i) |=> !valid_o); // R5
    AST_SC_NEEDS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
        sc_ok_o |-> $past(valid_o) && $past(sc_valid_i)); // R5
    AST_WAIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !lr_valid_i) |=> !valid_o); // R11

endmodule

// File: rtl/wrs_timer.sv
module wrs_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    output logic expired_o
);

    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)                      cnt_d = '0;
        else if (run_i && cnt_q != LAST)  cnt_d = cnt_q + 1'b1;
        expired_o = run_i && (cnt_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R8

endmodule

// File: rtl/wrs_stall_unit.sv
module wrs_stall_unit
    import wrs_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int GRAN_LSB    = 6,
    parameter int IRQ_W       = 16,
    parameter int TIMEOUT_CYC = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_valid,
    input  logic [31:0]      insn,
    input  logic             ext_en,
    input  logic             lr_valid,
    input  logic [XLEN-1:0]  lr_addr,
    input  logic             sc_valid,
    input  logic [XLEN-1:0]  sc_addr,
    input  logic             snoop_valid,
    input  logic [XLEN-1:0]  snoop_addr,
    input  logic [IRQ_W-1:0] irq_pending,
    input  logic             dbg_wake,
    output logic             stall,
    output logic             done,
    output logic             illegal,
    output logic             sc_ok
);

    wait_ctl_t ctl_d, ctl_q;
    logic is_nto, is_sto, is_wait;
    logic resv_valid, snoop_hit, wake_now, expired;
    logic complete, start_wait;

    wrs_decode u_decode (
        .insn_i   (insn),
        .is_nto_o (is_nto),
        .is_sto_o (is_sto)
    );

    wrs_resv #(.XLEN(XLEN), .GRAN_LSB(GRAN_LSB)) u_resv (
        .clk           (clk),
        .rst_n         (rst_n),
        .lr_valid_i    (lr_valid),
        .lr_addr_i     (lr_addr),
        .sc_valid_i    (sc_valid),
        .sc_addr_i     (sc_addr),
        .snoop_valid_i (snoop_valid),
        .snoop_addr_i  (snoop_addr),
        .clear_i       (complete),
        .valid_o       (resv_valid),
        .snoop_hit_o   (snoop_hit),
        .sc_ok_o       (sc_ok)
    );

    wrs_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_wait),
        .run_i     (ctl_q.state == ST_WAIT),
        .expired_o (expired)
    );

    always_comb begin
        is_wait    = insn_valid && (is_nto || is_sto);
        wake_now   = !resv_valid || snoop_hit || (|irq_pending) || dbg_wake;
        ctl_d         = ctl_q;
        ctl_d.done    = 1'b0;
        ctl_d.illegal = 1'b0;
        complete   = 1'b0;
        start_wait = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (is_wait) begin
                    if (!ext_en) begin
                        ctl_d.illegal = 1'b1;
                    end else if (wake_now) begin
                        ctl_d.done = 1'b1;
                        complete   = 1'b1;
                    end else begin
                        ctl_d.state = ST_WAIT;
                        ctl_d.stall = 1'b1;
                        ctl_d.timed = is_sto;
                        start_wait  = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (wake_now || (ctl_q.timed && expired)) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.stall = 1'b0;
                    ctl_d.done  = 1'b1;
                    complete    = 1'b1;
                end
            end
            default: ctl_d = ctl_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign stall   = ctl_q.stall;
    assign done    = ctl_q.done;
    assign illegal = ctl_q.illegal;

    AST_STALL_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && done)); // R7
    AST_STALL_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> done); // R7
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!stall && !done)); // R2
    AST_NO_RESV_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && is_wait && ext_en && !resv_valid) |=> (!stall && done)); // R6
    AST_IRQ_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && |irq_pending) |=> (!stall && done)); // R9
    AST_DBG_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && dbg_wake) |=> (!stall && done)); // R10

endmodule

// File: tb/wrs_stall_unit_bench.sv
module wrs_stall_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN  = 32;
    localparam int IRQ_W = 16;
    localparam int TO    = 256;
    localparam logic [31:0] W_NTO = 32'h00D00073;
    localparam logic [31:0] W_STO = 32'h01D00073;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic insn_valid, ext_en, lr_valid, sc_valid, snoop_valid, dbg_wake;
    logic [31:0] insn;
    logic [XLEN-1:0] lr_addr, sc_addr, snoop_addr;
    logic [IRQ_W-1:0] irq_pending;
    logic stall, done, illegal, sc_ok;

    int n_checks = 0;
    int n_fail   = 0;

    // model state
    logic        m_valid = 1'b0;
    logic [25:0] m_gran  = '0;
    logic        m_wait  = 1'b0;
    logic        m_timed = 1'b0;
    int          m_cnt   = 0;
    logic e_stall = 1'b0, e_done = 1'b0, e_ill = 1'b0, e_sc = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wrs_stall_unit #(.XLEN(XLEN), .IRQ_W(IRQ_W), .TIMEOUT_CYC(TO)) u_wrs_stall_unit (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn), .ext_en(ext_en),
        .lr_valid(lr_valid), .lr_addr(lr_addr), .sc_valid(sc_valid), .sc_addr(sc_addr),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .irq_pending(irq_pending),
        .dbg_wake(dbg_wake), .stall(stall), .done(done), .illegal(illegal), .sc_ok(sc_ok)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic idle();
        insn_valid = 0; insn = '0; ext_en = 1; lr_valid = 0; lr_addr = '0;
        sc_valid = 0; sc_addr = '0; snoop_valid = 0; snoop_addr = '0;
        irq_pending = '0; dbg_wake = 0;
    endtask

    function automatic logic [25:0] gran(input logic [31:0] a);
        return a[31:6];
    endfunction

    // one clock: predict from the requirements, advance, compare
    task automatic cyc(input string tag);
        logic hit, wake, compl, n_valid, n_wait, n_timed;
        logic [25:0] n_gran;
        int n_cnt;
        hit   = snoop_valid && m_valid && gran(snoop_addr) == m_gran;
        wake  = !m_valid || hit || (|irq_pending) || dbg_wake;
        compl = 0; n_wait = m_wait; n_timed = m_timed; n_cnt = m_cnt;
        e_done = 0; e_ill = 0;
        if (!m_wait) begin
            if (insn_valid && (insn == W_NTO || insn == W_STO)) begin
                if (!ext_en) e_ill = 1;
                else if (wake) begin e_done = 1; compl = 1; end
                else begin n_wait = 1; n_timed = (insn == W_STO); n_cnt = 0; end
            end
        end else if (wake || (m_timed && m_cnt == TO-1)) begin
            compl = 1; e_done = 1; n_wait = 0;
        end else if (m_cnt != TO-1) begin
            n_cnt = m_cnt + 1;
        end
        e_sc = sc_valid && m_valid && gran(sc_addr) == m_gran;
        n_valid = m_valid; n_gran = m_gran;
        if (lr_valid) begin n_valid = 1; n_gran = gran(lr_addr); end
        else if (sc_valid || hit || compl) n_valid = 0;
        @(posedge clk); #1;
        m_valid = n_valid; m_gran = n_gran; m_wait = n_wait; m_timed = n_timed; m_cnt = n_cnt;
        e_stall = m_wait;
        chk(tag, "stall", stall, e_stall);
        chk(tag, "done", done, e_done);
        chk(tag, "illegal", illegal, e_ill);
        chk(tag, "sc_ok", sc_ok, e_sc);
    endtask

    task automatic do_lr(input logic [31:0] a, input string tag);
        idle(); lr_valid = 1; lr_addr = a; cyc(tag); idle();
    endtask

    task automatic do_sc(input logic [31:0] a, input logic exp, input string tag);
        idle(); sc_valid = 1; sc_addr = a; cyc(tag); idle();
        chk(tag, "sc_ok direct", sc_ok, exp);
    endtask

    task automatic issue(input logic [31:0] w, input string tag);
        idle(); insn_valid = 1; insn = w; cyc(tag); idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        idle();
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        // R12 reset state
        chk("R12", "stall", stall, 0); chk("R12", "done", done, 0);
        chk("R12", "illegal", illegal, 0); chk("R12", "sc_ok", sc_ok, 0);
        do_sc(32'h1000, 0, "R12");

        // R6 no reservation: immediate done
        issue(W_NTO, "R6");
        chk("R6", "done", done, 1); chk("R6", "stall", stall, 0);
        cyc("R6");

        // R3 R5 store-conditional
        do_lr(32'h1000, "R3");
        do_sc(32'h1008, 1, "R5");
        do_sc(32'h1008, 0, "R5");
        do_lr(32'h1000, "R3");
        do_sc(32'h1040, 0, "R5");
        do_sc(32'h1000, 0, "R5");

        // R7 R4 snoop wake
        do_lr(32'h2010, "R3");
        idle(); snoop_valid = 1; snoop_addr = 32'h2040; cyc("R4"); idle();
        issue(W_NTO, "R7");
        chk("R7", "stall", stall, 1);
        repeat (20) cyc("R7");
        snoop_valid = 1; snoop_addr = 32'h3010; cyc("R4"); idle();
        chk("R4", "stall kept", stall, 1);
        snoop_valid = 1; snoop_addr = 32'h203C; cyc("R7"); idle();
        chk("R7", "done", done, 1); chk("R7", "stall", stall, 0);
        do_sc(32'h2010, 0, "R11");

        // R8 timed wait
        do_lr(32'h4000, "R3");
        issue(W_STO, "R8");
        n = 0;
        while (stall && n < 1000) begin n++; cyc("R8"); end
        chk("R8", "stall cycles == TO", n == TO, 1);
        chk("R8", "done", done, 1);

        // R8 untimed wait runs past the limit, R10 debug ends it
        do_lr(32'h4000, "R3");
        issue(W_NTO, "R8");
        repeat (TO + 40) cyc("R8");
        chk("R8", "still stalled", stall, 1);
        dbg_wake = 1; cyc("R10"); idle();
        chk("R10", "done", done, 1);
        do_sc(32'h4000, 0, "R11");

        // R9 masked-or-not interrupt
        do_lr(32'h5000, "R3");
        issue(W_STO, "R9");
        repeat (5) cyc("R9");
        irq_pending = 16'h0008; cyc("R9"); idle();
        chk("R9", "done", done, 1);

        // R2 disabled extension
        do_lr(32'h6000, "R3");
        idle(); ext_en = 0; insn_valid = 1; insn = W_STO; cyc("R2"); idle();
        chk("R2", "illegal", illegal, 1); chk("R2", "stall", stall, 0);
        do_sc(32'h6000, 1, "R2");

        // R1 single-bit variants of the encoding
        for (int b = 0; b < 32; b++) begin
            do_lr(32'h7000, "R1");
            idle(); ext_en = b[0]; insn_valid = 1; insn = W_NTO ^ (32'h1 << b);
            cyc("R1"); idle();
            if (stall) begin dbg_wake = 1; cyc("R1"); idle(); end
        end

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            int r;
            idle();
            r = $urandom_range(0, 99);
            ext_en = ($urandom_range(0, 9) != 0);
            if (r < 10) begin insn_valid = 1; insn = W_NTO; end
            else if (r < 18) begin insn_valid = 1; insn = W_STO; end
            else if (r < 22) begin insn_valid = 1; insn = $urandom; end
            lr_valid    = ($urandom_range(0, 9) == 0);
            lr_addr     = {20'h0, 2'($urandom_range(0, 3)), 4'h0, 6'($urandom)};
            sc_valid    = ($urandom_range(0, 15) == 0);
            sc_addr     = {20'h0, 2'($urandom_range(0, 3)), 4'h0, 6'($urandom)};
            snoop_valid = ($urandom_range(0, 19) == 0);
            snoop_addr  = {20'h0, 2'($urandom_range(0, 3)), 4'h0, 6'($urandom)};
            if ($urandom_range(0, 99) == 0) irq_pending = 16'(1 << $urandom_range(0, 15));
            dbg_wake    = ($urandom_range(0, 149) == 0);
            cyc("R7");
        end
        idle();
        cyc("R7");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule